// File: doc/BRIEF.md
# Motor Driver Standby and Fault Supervisor

This block decides, for each of two H-bridges of a motor driver, whether the bridge outputs may be driven. It watches the four bridge control inputs (two per bridge), a per-bridge overcurrent flag, an undervoltage flag and an over-temperature flag. It produces a standby indicator, a ready signal and one enable per bridge. The analog comparators and the gate sequencing of the bridges sit outside it. Every flag arrives as a synchronous digital input.

When all control inputs stay low long enough, the block enters a low-power standby. Any control input going high wakes it. The block then holds both bridges off for a settling interval before it raises ready. An overcurrent on one bridge latches a fault for that bridge alone. The latch clears only when standby is left or on reset. Undervoltage and over-temperature hold both bridges off for as long as the flag stays high, and neither one latches.

The time constants are given in microseconds, together with the clock frequency, and the cycle counts are derived from them. With the default 1 MHz clock, standby is entered after 1000 cycles and the settling interval is 30 cycles.

Top module: `motor_standby_supervisor`

## Requirements
- R1: `standby_o` rises on the clock edge at which the all-low condition (`ctl_in == 0`) has been sampled on STBY_CYC consecutive edges. STBY_CYC is 1000 at the default 1 MHz clock (1 ms).
- R2: Any bit of `ctl_in` sampled high before the timeout restarts the all-low count from zero. A later all-low run then needs a full STBY_CYC edges again.
- R3: On the first edge that samples any `ctl_in` bit high while in standby, `standby_o` falls. `ready_o` then stays low for WAKE_CYC edges in total and rises on the next one. WAKE_CYC is 30 by default (30 µs).
- R4: After reset the block is out of standby with `ready_o` low. Once the two-stage reset release has completed, it applies the same WAKE_CYC settling count before `ready_o` rises.
- R5: `bridge_en_o[i]` is high exactly when `ready_o` is high and bridge i has no latched or present overcurrent, and neither `uv_flag` nor `ot_flag` is high. `ready_o` and `standby_o` are never high together.
- R6: `ocp_flag[i]` high drops `bridge_en_o[i]` in the same cycle and latches a fault for bridge i only. The other bridge's enable is unaffected.
- R7: A latched overcurrent fault stays set after `ocp_flag[i]` falls. It is cleared only by a standby exit or by reset.
- R8: While `uv_flag` is high, both enables are low.
- R9: While `ot_flag` is high, both enables are low. When the flag falls, the enables return in the same cycle with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_in | input | 4 | Bridge control inputs, two per bridge |
| ocp_flag | input | 2 | Overcurrent flag per bridge |
| uv_flag | input | 1 | Supply undervoltage flag |
| ot_flag | input | 1 | Over-temperature flag |
| standby_o | output | 1 | High while in low-power standby |
| ready_o | output | 1 | High once settling after reset or wake is done |
| bridge_en_o | output | 2 | Drive permission per bridge |

## Verification
The bench checks the standby timeout one edge short of and exactly at STBY_CYC. A counter off by one either way shows up there. It breaks an all-low run one cycle before timeout, and a timer that fails to restart then enters standby early. It counts the settling interval edge by edge after reset and after wake, which catches a ready that comes up early or a missing clear of the count.

For faults, the bench pulses an overcurrent on one bridge and checks that the other bridge stays enabled. It then checks that the latch survives the flag's fall and is cleared only by a standby round trip. It also confirms that an over-temperature flag recovers by itself, which a design that wrongly latched it would fail.

// File: rtl/mdsup_pkg.sv
package mdsup_pkg;

  typedef enum logic [1:0] {
    PH_WAKE = 2'd0,
    PH_RUN  = 2'd1,
    PH_STBY = 2'd2
  } phase_e;

  function automatic int us_to_cycles(input int clk_hz, input int us);
    int c;
    c = (clk_hz / 1000) * us / 1000;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/mdsup_idle_timer.sv
module mdsup_idle_timer #(
  parameter int CTL_W    = 4,
  parameter int STBY_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             hold_i,
  output logic             timeout_o
);
  localparam int CW = $clog2(STBY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STBY_CYC - 1);

  logic          all_low;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign all_low = (ctl_i == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (hold_i || !all_low) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign timeout_o = all_low && !hold_i && (cnt_q == LAST);

  // R2: a high control input leaves the count at zero on the next edge
  a_r2_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_low) |=> (cnt_q == '0 && !timeout_o) || all_low);

endmodule

// File: rtl/mdsup_phase_fsm.sv
module mdsup_phase_fsm
  import mdsup_pkg::*;
#(
  parameter int CTL_W    = 4,
  parameter int WAKE_CYC = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             timeout_i,
  output phase_e           phase_o,
  output logic             wake_pulse_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [WW-1:0] wc_q, wc_d;
  logic          any_high;

  assign any_high = (ctl_i != '0);

  always_comb begin
    ph_d         = ph_q;
    wc_d         = wc_q;
    wake_pulse_o = 1'b0;
    unique case (ph_q)
      PH_WAKE: begin
        if (timeout_i) begin
          ph_d = PH_STBY;
          wc_d = '0;
        end else if (wc_q == WLAST) begin
          ph_d = PH_RUN;
          wc_d = '0;
        end else begin
          wc_d = wc_q + 1'b1;
        end
      end
      PH_RUN: begin
        if (timeout_i) ph_d = PH_STBY;
      end
      PH_STBY: begin
        if (any_high) begin
          ph_d         = PH_WAKE;
          wc_d         = '0;
          wake_pulse_o = 1'b1;
        end
      end
      default: begin
        ph_d = PH_WAKE;
        wc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_WAKE;
      wc_q <= '0;
    end else begin
      ph_q <= ph_d;
      wc_q <= wc_d;
    end
  end

  assign phase_o = ph_q;

  // R3: leaving standby always passes through the settling phase
  a_r3_wake_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STBY && any_high) |=> (ph_q == PH_WAKE));

  // R3: run is only reached from the settling phase
  a_r3_run_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && $past(ph_q) != PH_RUN) |-> ($past(ph_q) == PH_WAKE));

endmodule

// File: rtl/mdsup_fault_latch.sv
module mdsup_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic stby_i,
  input  logic clr_i,
  output logic lat_o
);
  logic lat_q, lat_d, lat_en;

  always_comb begin
    lat_d  = lat_q;
    lat_en = 1'b0;
    if (clr_i) begin
      lat_d  = 1'b0;
      lat_en = lat_q;
    end else if (flag_i && !stby_i) begin
      lat_d  = 1'b1;
      lat_en = !lat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  // R7: a set latch survives everything except a clear
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr_i) |=> lat_q);

  // R6: a flag outside standby sets the latch
  a_r6_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && !stby_i && !clr_i) |=> lat_q);

endmodule

// File: rtl/motor_standby_supervisor.sv
module motor_standby_supervisor
  import mdsup_pkg::*;
#(
  parameter int CLK_HZ   = 1_000_000,
  parameter int STBY_US  = 1000,
  parameter int WAKE_US  = 30,
  parameter int N_BRIDGE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*N_BRIDGE-1:0] ctl_in,
  input  logic [N_BRIDGE-1:0]   ocp_flag,
  input  logic                  uv_flag,
  input  logic                  ot_flag,
  output logic                  standby_o,
  output logic                  ready_o,
  output logic [N_BRIDGE-1:0]   bridge_en_o
);
  localparam int CTL_W    = 2 * N_BRIDGE;
  localparam int STBY_CYC = us_to_cycles(CLK_HZ, STBY_US);
  localparam int WAKE_CYC = us_to_cycles(CLK_HZ, WAKE_US);

  logic   rs_meta_q, rs_q;
  logic   timeout;
  logic   wake_pulse;
  logic   in_stby;
  phase_e phase;
  logic [N_BRIDGE-1:0] fault_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  assign in_stby = (phase == PH_STBY);

  mdsup_idle_timer #(.CTL_W(CTL_W), .STBY_CYC(STBY_CYC)) u_idle (
    .clk       (clk),
    .rst_n     (rs_q),
    .ctl_i     (ctl_in),
    .hold_i    (in_stby),
    .timeout_o (timeout)
  );

  mdsup_phase_fsm #(.CTL_W(CTL_W), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rs_q),
    .ctl_i        (ctl_in),
    .timeout_i    (timeout),
    .phase_o      (phase),
    .wake_pulse_o (wake_pulse)
  );

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
    mdsup_fault_latch u_lat (
      .clk    (clk),
      .rst_n  (rs_q),
      .flag_i (ocp_flag[b]),
      .stby_i (in_stby),
      .clr_i  (wake_pulse),
      .lat_o  (fault_lat[b])
    );
    assign bridge_en_o[b] = ready_o && !fault_lat[b] && !ocp_flag[b]
                            && !uv_flag && !ot_flag;
  end

  assign standby_o = in_stby;
  assign ready_o   = (phase == PH_RUN);

  // R5: ready and standby never coincide
  a_r5_ready_excl: assert property (@(posedge clk) disable iff (!rs_q)
    !(ready_o && standby_o));

  // R1: standby only begins after an all-low sample
  a_r1_stby_entry: assert property (@(posedge clk) disable iff (!rs_q)
    $rose(standby_o) |-> ($past(ctl_in) == '0));

  // R8: undervoltage keeps every bridge off
  a_r8_uv_off: assert property (@(posedge clk) disable iff (!rs_q)
    uv_flag |-> (bridge_en_o == '0));

  // R9: over-temperature keeps every bridge off
  a_r9_ot_off: assert property (@(posedge clk) disable iff (!rs_q)
    ot_flag |-> (bridge_en_o == '0));

endmodule

// File: tb/motor_standby_supervisor_tb.sv
module motor_standby_supervisor_tb;
  localparam int STBY = 1000;
  localparam int WAKE = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ctl_in;
  logic [1:0] ocp_flag;
  logic       uv_flag, ot_flag;
  logic       standby_o, ready_o;
  logic [1:0] bridge_en_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  motor_standby_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .ocp_flag(ocp_flag),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .standby_o(standby_o),
    .ready_o(ready_o), .bridge_en_o(bridge_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge(input logic [3:0] c);
    @(negedge clk);
    ctl_in = c;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready_o; i++) edges(1);
  endtask

  // R4: reset state and first settling
  task automatic t_reset();
    rst_n = 1'b0; ctl_in = 4'b0101; ocp_flag = '0; uv_flag = 0; ot_flag = 0;
    #20;
    #1;
    check("R4 reset standby", standby_o, 0);
    check("R4 reset ready", ready_o, 0);
    check("R4 reset enables", bridge_en_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges(WAKE + 1);
    check("R4 ready still low", ready_o, 0);
    edges(1);
    check("R4 ready up", ready_o, 1);
    check("R5 both enabled", bridge_en_o, 3);
  endtask

  // R1: standby exactly at STBY edges
  task automatic t_standby_entry();
    drive_at_negedge(4'b0000);
    edges(STBY - 1);
    check("R1 not yet standby", standby_o, 0);
    check("R5 enabled before timeout", bridge_en_o, 3);
    edges(1);
    check("R1 standby", standby_o, 1);
    check("R5 ready low in standby", ready_o, 0);
    check("R5 enables low in standby", bridge_en_o, 0);
  endtask

  // R3: wake settling
  task automatic t_wake();
    drive_at_negedge(4'b1000);
    edges(1);
    check("R3 standby left", standby_o, 0);
    check("R3 ready low", ready_o, 0);
    edges(WAKE - 1);
    check("R3 ready low at end", ready_o, 0);
    check("R3 bridges off while settling", bridge_en_o, 0);
    edges(1);
    check("R3 ready up", ready_o, 1);
  endtask

  // R2: restart of the idle count
  task automatic t_restart();
    drive_at_negedge(4'b0000);
    edges(STBY - 2);
    drive_at_negedge(4'b0010);
    drive_at_negedge(4'b0000);
    edges(STBY - 1);
    check("R2 no early standby", standby_o, 0);
    edges(1);
    check("R2 standby after full run", standby_o, 1);
    drive_at_negedge(4'b0001);
    wait_ready();
    check("R2 back to ready", ready_o, 1);
  endtask

  // R6 R7: overcurrent latch
  task automatic t_ocp();
    @(negedge clk); ocp_flag = 2'b01; #1;
    check("R6 bridge0 off same cycle", bridge_en_o, 2);
    @(negedge clk); ocp_flag = 2'b00;
    edges(3);
    check("R7 latch held", bridge_en_o, 2);
    check("R6 ready kept", ready_o, 1);
    @(negedge clk); ocp_flag = 2'b10;
    @(negedge clk); ocp_flag = 2'b00;
    edges(2);
    check("R6 both latched", bridge_en_o, 0);
    drive_at_negedge(4'b0000);
    edges(STBY);
    check("R7 standby", standby_o, 1);
    drive_at_negedge(4'b0100);
    wait_ready();
    check("R7 cleared by wake", bridge_en_o, 3);
  endtask

  // R8 R9: undervoltage and over-temperature
  task automatic t_uv_ot();
    @(negedge clk); uv_flag = 1; #1;
    check("R8 uv off", bridge_en_o, 0);
    @(negedge clk); uv_flag = 0; #1;
    check("R8 uv recovered", bridge_en_o, 3);
    @(negedge clk); ot_flag = 1; #1;
    check("R9 ot off", bridge_en_o, 0);
    edges(5);
    check("R9 ot still off", bridge_en_o, 0);
    @(negedge clk); ot_flag = 0; #1;
    check("R9 ot recovered", bridge_en_o, 3);
    check("R9 ready unaffected", ready_o, 1);
  endtask

  // R7: reset clears a latch
  task automatic t_reset_clear();
    @(negedge clk); ocp_flag = 2'b10;
    @(negedge clk); ocp_flag = 2'b00; #1;
    check("R7 latched before reset", bridge_en_o, 1);
    rst_n = 1'b0;
    #10;
    @(negedge clk); rst_n = 1'b1;
    wait_ready();
    check("R7 reset cleared latch", bridge_en_o, 3);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_standby_entry();
        t_wake();
        t_restart();
        t_ocp();
        t_uv_ot();
        t_reset_clear();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule